// File: doc/BRIEF.md
# Keyed SDRAM Refresh Request Timer

This block paces auto-refresh for an SDRAM controller. A free-running prescaler divides the bus clock by a selectable ratio to make a slow tick. A tick counter runs up to a programmed compare value, then restarts from zero. Each compare match sets a sticky match flag. It also loads an owed-refresh counter with a programmable burst size. While refreshes are owed, the block holds its request line high. The command sequencer answers each refresh it issues with a one-cycle acknowledge, and each acknowledge retires one owed refresh.

Software programs the block through a simple 32-bit register port. Both writable registers are guarded by a protection key: a write changes state only when the upper halfword of the write data equals 0xA55A. This guards the refresh timing against stray stores. Reads return the register contents in the low halfword and zero above it.

With a 16x prescale of a 132 MHz bus clock and a compare value of 0x40, matches arrive roughly every 7.8 µs.

Top module: `rfsh_req_timer`

## Requirements
- R1: After reset, all registers read as zero, `rfsh_req` is low, `rfsh_owed` is 0, and the tick counter does not advance.
- R2: A write to the control register (address 0) or the compare register (address 1) takes effect only when `bus_wdata[31:16]` equals 0xA55A. Any other key leaves every register unchanged.
- R3: The clock-select field, control bits 2:0, sets the tick period. Code 000 stops the counter. Codes 001 to 111 give ratios of 4, 16, 64, 256, 1024, 2048 and 4096 bus clocks. An accepted control write restarts the prescaler, so the first tick follows that write by exactly one full ratio.
- R4: Each tick increments the counter. A tick that finds the counter equal to the compare value clears it to zero instead and counts as a match, so the match period is (compare+1) ticks. An accepted compare write clears the counter.
- R5: The match flag, control bit 8, is set by a match. A keyed control write with bit 8 at 0 clears the flag. Writing 1 to bit 8 leaves the flag unchanged. A match in the same cycle as a clear wins.
- R6: The burst field, control bits 6:4, selects the refreshes requested per match. Codes 000 to 100 request 1, 2, 4, 6 and 8, and codes 101 to 111 request 8. A match replaces the owed count with this value; it does not add to it.
- R7: Each cycle with `rfsh_ack` high and a nonzero owed count decrements the count by one. An acknowledge with nothing owed is ignored. `rfsh_req` is high exactly when the owed count is nonzero.
- R8: The read map is as follows: address 0 is control, 1 is compare, 2 is the live counter, and 3 reads zero. Bits 31:16 always read zero. Writes to addresses 2 and 3 change nothing.
- R9: With ratio 16 and a compare value of 0x40, the first match lands 1040 bus clocks after the arming control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable, qualifies `bus_sel` |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data, key in bits 31:16 |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rfsh_ack | input | 1 | One refresh issued by the sequencer |
| rfsh_req | output | 1 | Refreshes are owed |
| rfsh_owed | output | 4 | Number of refreshes still owed |

## Verification
The embedded properties assume a few things about the inputs. They assume `rfsh_ack` is a plain per-cycle pulse that may arrive in any cycle, including when nothing is owed. They assume the counter never wraps past all ones, because the compare value is always written before the timer is armed, and the compare write clears the count. The stimulus keeps to these assumptions. It stops the timer and rewrites the compare value before each new arming, it drives bus signals only on falling edges, and it sends some acknowledges with nothing owed, to exercise the ignore path.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  localparam int ADR_CTRL  = 0;
  localparam int ADR_CMP   = 1;
  localparam int ADR_COUNT = 2;

  localparam int CSEL_LSB  = 0;
  localparam int BURST_LSB = 4;
  localparam int FLAG_BIT  = 8;

  // refreshes owed per compare match, by burst code
  function automatic logic [3:0] burst_count(input logic [2:0] code);
    case (code)
      3'd0:    burst_count = 4'd1;
      3'd1:    burst_count = 4'd2;
      3'd2:    burst_count = 4'd4;
      3'd3:    burst_count = 4'd6;
      default: burst_count = 4'd8;
    endcase
  endfunction

  // log2 of the prescale ratio for a nonzero clock-select code
  function automatic int unsigned div_log2(input logic [2:0] code);
    case (code)
      3'd1:    div_log2 = 2;
      3'd2:    div_log2 = 4;
      3'd3:    div_log2 = 6;
      3'd4:    div_log2 = 8;
      3'd5:    div_log2 = 10;
      3'd6:    div_log2 = 11;
      3'd7:    div_log2 = 12;
      default: div_log2 = 0;
    endcase
  endfunction
endpackage

// File: rtl/rfsh_prescaler.sv
module rfsh_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [2:0] csel,
  output logic       tick
);
  import rfsh_pkg::*;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask = PRE_W'((32'd1 << div_log2(csel)) - 32'd1);
    tick = (csel != 3'd0) && ((pre_q & mask) == mask);
    pre_d = restart ? '0 : pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R3: the shortest ratio is 4, so ticks never come back to back
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/rfsh_tick_counter.sv
module rfsh_tick_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] count,
  output logic             match
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    match = tick && (cnt_q == cmp_val);
    cnt_d = cnt_q;
    if (clr)        cnt_d = '0;
    else if (match) cnt_d = '0;
    else if (tick)  cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R4: a non-matching tick adds exactly one
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !match && !clr) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  // R4: a match restarts the count at zero
  a_r4_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (cnt_q == '0));
  // R1: without a tick or clear the count holds
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/rfsh_regs.sv
module rfsh_regs #(
  parameter int          ADDR_W = 2,
  parameter int          CNT_W  = 16,
  parameter logic [15:0] KEY    = 16'hA55A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              match,
  output logic [2:0]        csel,
  output logic [2:0]        burst,
  output logic              flag,
  output logic [CNT_W-1:0]  cmp_val,
  output logic              ctrl_wr,
  output logic              cmp_wr
);
  import rfsh_pkg::*;

  logic             key_ok;
  logic [2:0]       csel_q, csel_d;
  logic [2:0]       burst_q, burst_d;
  logic             flag_q, flag_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;

  always_comb begin
    key_ok  = bus_sel && bus_we && (bus_wdata[31:16] == KEY);
    ctrl_wr = key_ok && (bus_addr == ADDR_W'(ADR_CTRL));
    cmp_wr  = key_ok && (bus_addr == ADDR_W'(ADR_CMP));

    csel_d  = csel_q;
    burst_d = burst_q;
    cmp_d   = cmp_q;
    flag_d  = flag_q;
    if (ctrl_wr) begin
      csel_d  = bus_wdata[CSEL_LSB +: 3];
      burst_d = bus_wdata[BURST_LSB +: 3];
      if (!bus_wdata[FLAG_BIT]) flag_d = 1'b0;
    end
    if (match) flag_d = 1'b1;
    if (cmp_wr) cmp_d = bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csel_q  <= '0;
      burst_q <= '0;
      flag_q  <= 1'b0;
      cmp_q   <= '0;
    end else begin
      csel_q  <= csel_d;
      burst_q <= burst_d;
      flag_q  <= flag_d;
      cmp_q   <= cmp_d;
    end
  end

  assign csel    = csel_q;
  assign burst   = burst_q;
  assign flag    = flag_q;
  assign cmp_val = cmp_q;

  // R2: a write with a wrong key leaves the registers untouched
  a_r2_keyless_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && (bus_wdata[31:16] != KEY))
      |=> ($stable(csel_q) && $stable(burst_q) && $stable(cmp_q)));
  // R5: the flag only rises after a compare match
  a_r5_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(match));
endmodule

// File: rtl/rfsh_owed_ctr.sv
module rfsh_owed_ctr #(
  parameter int OWED_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              match,
  input  logic [2:0]        burst,
  input  logic              ack,
  output logic [OWED_W-1:0] owed
);
  import rfsh_pkg::*;

  logic [OWED_W-1:0] owed_q, owed_d;
  logic              retire;

  always_comb begin
    retire = ack && (owed_q != '0);
    owed_d = owed_q;
    if (match)       owed_d = OWED_W'(burst_count(burst));
    else if (retire) owed_d = owed_q - OWED_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owed_q <= '0;
    else        owed_q <= owed_d;
  end

  assign owed = owed_q;

  // R6: a match loads the burst size for the programmed code
  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (owed_q == OWED_W'(burst_count($past(burst)))));
  // R7: an acknowledge retires exactly one owed refresh
  a_r7_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !match && (owed_q != '0)) |=> (owed_q == $past(owed_q) - OWED_W'(1)));
  // R7: an acknowledge with nothing owed does nothing
  a_r7_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!match && (owed_q == '0)) |=> (owed_q == '0));
  // R6: the owed count never exceeds the largest burst
  a_r6_bound: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q <= OWED_W'(8));
endmodule

// File: rtl/rfsh_req_timer.sv
module rfsh_req_timer #(
  parameter int          ADDR_W = 2,
  parameter int          CNT_W  = 16,
  parameter int          PRE_W  = 12,
  parameter int          OWED_W = 4,
  parameter logic [15:0] KEY    = 16'hA55A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rfsh_ack,
  output logic              rfsh_req,
  output logic [OWED_W-1:0] rfsh_owed
);
  import rfsh_pkg::*;

  logic [1:0]       rst_pipe;
  logic             rst_ni;
  logic [2:0]       csel, burst;
  logic             flag, ctrl_wr, cmp_wr, tick, match;
  logic [CNT_W-1:0] cmp_val, count;
  logic [15:0]      ctrl_view;

  // reset asserts at once and leaves on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  rfsh_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .KEY(KEY)) u_regs (
    .clk(clk), .rst_n(rst_ni), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .match(match),
    .csel(csel), .burst(burst), .flag(flag), .cmp_val(cmp_val),
    .ctrl_wr(ctrl_wr), .cmp_wr(cmp_wr)
  );

  rfsh_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_ni), .restart(ctrl_wr), .csel(csel), .tick(tick)
  );

  rfsh_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_ni), .tick(tick), .clr(cmp_wr),
    .cmp_val(cmp_val), .count(count), .match(match)
  );

  rfsh_owed_ctr #(.OWED_W(OWED_W)) u_owed (
    .clk(clk), .rst_n(rst_ni), .match(match), .burst(burst),
    .ack(rfsh_ack), .owed(rfsh_owed)
  );

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CSEL_LSB +: 3]  = csel;
    ctrl_view[BURST_LSB +: 3] = burst;
    ctrl_view[FLAG_BIT]       = flag;
    case (bus_addr)
      ADDR_W'(ADR_CTRL):  bus_rdata = {16'h0, ctrl_view};
      ADDR_W'(ADR_CMP):   bus_rdata = {16'h0, 16'(cmp_val)};
      ADDR_W'(ADR_COUNT): bus_rdata = {16'h0, 16'(count)};
      default:            bus_rdata = '0;
    endcase
  end

  assign rfsh_req = (rfsh_owed != '0);

  // R7: the request drops only after an acknowledge
  a_r7_req_falls_on_ack: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(rfsh_req) |-> $past(rfsh_ack));
  // R8: the upper halfword never carries data
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    bus_rdata[31:16] == 16'h0);
endmodule

// File: tb/rfsh_req_timer_bench.sv
module rfsh_req_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0, rfsh_ack = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rfsh_req;
  logic [3:0]  rfsh_owed;

  int checks = 0;
  int errors = 0;

  localparam logic [15:0] KEY = 16'hA55A;

  always #5 clk = ~clk;

  rfsh_req_timer u_rfsh_req_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rfsh_ack(rfsh_ack), .rfsh_req(rfsh_req), .rfsh_owed(rfsh_owed)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] k, input logic [15:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = {k, d};
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic ack_pulse;
    rfsh_ack = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rfsh_ack = 1'b0;
  endtask

  function automatic logic [15:0] ctl(input logic [2:0] cs, input logic [2:0] bu,
                                      input logic fl);
    return {7'b0, fl, 1'b0, bu, 1'b0, cs};
  endfunction

  // stop, load compare (clears count), then arm; returns after edge E0
  task automatic arm(input logic [15:0] cmp, input logic [15:0] c);
    wr(2'd0, KEY, 16'h0);
    wr(2'd1, KEY, cmp);
    wr(2'd0, KEY, c);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1", "register after reset", v, 32'h0);
    end
    chk("R1", "req after reset", {31'b0, rfsh_req}, 32'h0);
    chk("R1", "owed after reset", {28'b0, rfsh_owed}, 32'h0);
    step(20);
    rd(2'd2, v);
    chk("R1", "counter idle", v, 32'h0);
  endtask

  task automatic t_key;
    logic [31:0] v;
    wr(2'd0, 16'h1234, ctl(3'd1, 3'd2, 1'b0));
    rd(2'd0, v);
    chk("R2", "ctrl with bad key", v, 32'h0);
    wr(2'd1, 16'hA55B, 16'h0077);
    rd(2'd1, v);
    chk("R2", "compare with bad key", v, 32'h0);
    wr(2'd1, KEY, 16'h0123);
    rd(2'd1, v);
    chk("R2", "compare with key", v, 32'h0000_0123);
    wr(2'd0, KEY, ctl(3'd0, 3'd3, 1'b0));
    rd(2'd0, v);
    chk("R2", "ctrl with key", v, {16'h0, ctl(3'd0, 3'd3, 1'b0)});
  endtask

  task automatic t_read_map;
    logic [31:0] v;
    wr(2'd2, KEY, 16'h0055);
    rd(2'd2, v);
    chk("R8", "counter not writable", v, 32'h0);
    wr(2'd3, KEY, 16'hFFFF);
    rd(2'd3, v);
    chk("R8", "address 3 reads zero", v, 32'h0);
    rd(2'd1, v);
    chk("R8", "compare unaffected by addr 3 write", v, 32'h0000_0123);
  endtask

  task automatic t_divs;
    logic [31:0] v;
    int ratio;
    arm(16'hFFFF, ctl(3'd0, 3'd0, 1'b0));
    step(50);
    rd(2'd2, v);
    chk("R3", "code 0 stopped", v, 32'h0);
    for (int c = 1; c < 8; c++) begin
      case (c)
        1: ratio = 4;    2: ratio = 16;   3: ratio = 64;  4: ratio = 256;
        5: ratio = 1024; 6: ratio = 2048; default: ratio = 4096;
      endcase
      arm(16'hFFFF, ctl(3'(c), 3'd0, 1'b0));
      step(ratio - 1);
      rd(2'd2, v);
      chk("R3", $sformatf("code %0d before first tick", c), v, 32'h0);
      step(1);
      rd(2'd2, v);
      chk("R3", $sformatf("code %0d first tick", c), v, 32'h1);
    end
  endtask

  task automatic t_match;
    logic [31:0] v;
    arm(16'd2, ctl(3'd1, 3'd0, 1'b0));
    step(4);
    rd(2'd2, v);
    chk("R4", "count after one tick", v, 32'h1);
    step(7);
    rd(2'd2, v);
    chk("R4", "count at compare", v, 32'h2);
    rd(2'd0, v);
    chk("R5", "flag before match", v[8], 1'b0);
    chk("R7", "req before match", rfsh_req, 1'b0);
    step(1);
    rd(2'd2, v);
    chk("R4", "count clears on match", v, 32'h0);
    rd(2'd0, v);
    chk("R5", "flag after match", v[8], 1'b1);
    chk("R6", "owed code 0", rfsh_owed, 4'd1);
    chk("R7", "req after match", rfsh_req, 1'b1);
  endtask

  task automatic t_flag;
    logic [31:0] v;
    wr(2'd0, KEY, ctl(3'd0, 3'd0, 1'b1));
    rd(2'd0, v);
    chk("R5", "writing 1 keeps flag", v[8], 1'b1);
    wr(2'd0, 16'h0000, ctl(3'd0, 3'd0, 1'b0));
    rd(2'd0, v);
    chk("R5", "unkeyed clear ignored", v[8], 1'b1);
    wr(2'd0, KEY, ctl(3'd0, 3'd0, 1'b0));
    rd(2'd0, v);
    chk("R5", "keyed clear", v[8], 1'b0);
    ack_pulse();
  endtask

  task automatic t_bursts;
    logic [3:0] exp;
    for (int c = 0; c < 8; c++) begin
      case (c)
        0: exp = 4'd1; 1: exp = 4'd2; 2: exp = 4'd4; 3: exp = 4'd6;
        default: exp = 4'd8;
      endcase
      arm(16'd0, ctl(3'd1, 3'(c), 1'b0));
      step(4);
      chk("R6", $sformatf("burst code %0d", c), rfsh_owed, exp);
    end
    wr(2'd0, KEY, ctl(3'd0, 3'd0, 1'b0));
    for (int i = 0; i < 8; i++) ack_pulse();
    chk("R7", "drained", rfsh_owed, 4'd0);
  endtask

  task automatic t_ack;
    arm(16'd0, ctl(3'd1, 3'd2, 1'b0));
    step(4);
    chk("R6", "loaded 4", rfsh_owed, 4'd4);
    wr(2'd0, KEY, ctl(3'd0, 3'd2, 1'b0));
    for (int i = 0; i < 3; i++) ack_pulse();
    chk("R7", "three acks", rfsh_owed, 4'd1);
    chk("R7", "req still high", rfsh_req, 1'b1);
    arm(16'd0, ctl(3'd1, 3'd1, 1'b0));
    step(4);
    chk("R6", "match replaces owed", rfsh_owed, 4'd2);
    wr(2'd0, KEY, ctl(3'd0, 3'd1, 1'b0));
    ack_pulse();
    ack_pulse();
    chk("R7", "owed empty", rfsh_owed, 4'd0);
    chk("R7", "req low", rfsh_req, 1'b0);
    ack_pulse();
    chk("R7", "ack with nothing owed", rfsh_owed, 4'd0);
  endtask

  task automatic t_nominal;
    logic [31:0] v;
    arm(16'h0040, ctl(3'd2, 3'd0, 1'b0));
    step(1039);
    rd(2'd0, v);
    chk("R9", "no match at 1039", v[8], 1'b0);
    step(1);
    rd(2'd0, v);
    chk("R9", "match at 1040", v[8], 1'b1);
    chk("R9", "one refresh owed", rfsh_owed, 4'd1);
    rd(2'd2, v);
    chk("R9", "count cleared", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(5);
    t_reset();
    t_key();
    t_read_map();
    t_divs();
    t_match();
    t_flag();
    t_bursts();
    t_ack();
    t_nominal();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule